// File: doc/BRIEF.md
# Serial Nonvolatile RAM Slave Model

This block models a small serial memory with sixteen 16-bit words. It has a working RAM and a shadow nonvolatile copy of the same size. A host selects the device with a chip-enable, then clocks instruction and data bits in on a serial clock. The block samples those pins with its own system clock, so all of its state sits in one clock domain. One byte carries both the operation and the word address. The block can read and write single RAM words, copy the whole shadow array into RAM (recall), copy the whole RAM into the shadow array (store), enter a power-down state, and set or clear a write-enable latch. Because the address is inside the opcode, no separate address phase is needed.

The data output is a tri-state pair: `dout` carries the value and `dout_en` is the drive enable. A read is recognised after the seventh instruction bit. The output starts driving only after the eighth clock, so a host that shares one pin for data in and data out has a full clock period to release the line. The block is meant as a checking partner for a serial-memory master.

Top module: `snvram`

## Requirements
- R1: An instruction is the byte `1,A3,A2,A1,A0,P2,P1,P0`, shifted in MSB first, one bit per rising edge of `sclk` while `cs` is high. Zeros that come before the leading 1 are skipped.
- R2: Operation code 100 sets the write-enable latch. Operation code 000 clears it.
- R3: Operation code 011 is followed by 16 data bits, MSB first. The word is written to RAM at address A on the 24th rising edge, and only if the write-enable latch is set.
- R4: Operation code 110 is a read. It is recognised after the 7th bit, and the 8th bit is a don't-care. On the 8th rising edge `dout_en` goes high with D15 on `dout`. Each later rising edge presents the next lower bit, so D0 appears after the 23rd. On the 24th rising edge the output is released.
- R5: Operation code 101 (recall) copies the whole nonvolatile array into RAM. It sets the recall latch, clears the write-enable latch and clears power-down.
- R6: Operation code 001 (store) copies the whole RAM into the nonvolatile array, but only when both the recall latch and the write-enable latch are set.
- R7: Operation code 010 sets power-down. While power-down is set, every instruction except recall is ignored, and a read never drives `dout_en`.
- R8: `cs` low aborts any partial instruction, releases the output and restarts bit counting. If `cs` falls in the same cycle as an `sclk` rising edge, the fall wins and that edge is not taken.
- R9: Only one instruction is accepted per selection. Bits after a completed instruction are ignored until `cs` goes low.
- R10: After reset, all latches are clear, both arrays hold zero and `dout_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock; bits are taken on its rising edge |
| din | input | 1 | Serial data in |
| dout | output | 1 | Serial data out (meaningful only when enabled) |
| dout_en | output | 1 | Output drive enable; low means high impedance |

## Verification
Two events can land in the same cycle: chip-select falling and the serial clock edge that completes a write. The bench provokes this by raising `sclk` for the 24th bit and dropping `cs` in the same cycle. It then reads the word back and expects the old value. A normal write to the same address afterwards must succeed, which shows the write-enable latch survived the aborted attempt.

// File: rtl/snvram.sv
module snvram #(
  parameter int WIDTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sclk,
  input  logic din,
  output logic dout,
  output logic dout_en
);
  localparam int WORDS = 16;
  localparam int LAST  = 8 + WIDTH - 1;
  localparam int CW    = $clog2(LAST + 2);

  logic                        sclk_q;
  logic [CW-1:0]               cnt;
  logic [6:0]                  opc;
  logic [WIDTH-1:0]            sh;
  logic                        rd, done, wel, rcl, pd, drv, dq;
  logic [WORDS-1:0][WIDTH-1:0] ram, nv;

  wire       rise   = sclk & ~sclk_q;
  wire [2:0] op_now = {opc[1:0], din};

  assign dout    = drv & dq;
  assign dout_en = drv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cnt    <= '0;
      opc    <= '0;
      sh     <= '0;
      rd     <= 1'b0;
      done   <= 1'b0;
      wel    <= 1'b0;
      rcl    <= 1'b0;
      pd     <= 1'b0;
      drv    <= 1'b0;
      dq     <= 1'b0;
      ram    <= '0;
      nv     <= '0;
    end else begin
      sclk_q <= sclk;
      if (!cs) begin
        cnt  <= '0;
        done <= 1'b0;
        rd   <= 1'b0;
        drv  <= 1'b0;
      end else if (rise && !done && !(cnt == '0 && !din)) begin
        cnt <= cnt + CW'(1);
        if (cnt < CW'(8))
          opc <= {opc[5:0], din};
        if (cnt == CW'(6) && opc[0] && din && !pd) begin
          rd <= 1'b1;
          sh <= ram[opc[4:1]];
        end
        if (cnt == CW'(7)) begin
          if (rd) begin
            drv <= 1'b1;
            dq  <= sh[WIDTH-1];
            sh  <= sh << 1;
          end else begin
            done <= 1'b1;
            if (!pd || op_now == 3'b101) begin
              case (op_now)
                3'b000: wel <= 1'b0;
                3'b001: if (rcl && wel) nv <= ram;
                3'b010: pd <= 1'b1;
                3'b011: done <= 1'b0;
                3'b100: wel <= 1'b1;
                3'b101: begin
                  ram <= nv;
                  rcl <= 1'b1;
                  wel <= 1'b0;
                  pd  <= 1'b0;
                end
                default: ;
              endcase
            end
          end
        end else if (cnt > CW'(7)) begin
          if (rd) begin
            if (cnt == CW'(LAST)) begin
              drv  <= 1'b0;
              done <= 1'b1;
            end else begin
              dq <= sh[WIDTH-1];
              sh <= sh << 1;
            end
          end else begin
            sh <= {sh[WIDTH-2:0], din};
            if (cnt == CW'(LAST)) begin
              done <= 1'b1;
              if (wel) ram[opc[6:3]] <= {sh[WIDTH-2:0], din};
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/snvram_chk.sv
module snvram_chk #(
  parameter int WIDTH = 16,
  parameter int CW    = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cs,
  input logic                  dout_en,
  input logic                  wel,
  input logic                  rcl,
  input logic                  pd,
  input logic [15:0][WIDTH-1:0] nv,
  input logic [CW-1:0]         cnt
);
  a_r8_release_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> !dout_en);

  a_r4_drive_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_en) |-> $past(cs));

  a_r7_no_enable_in_pd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> !$past(pd));

  a_r5_recall_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rcl) |-> !wel);

  a_r5_pd_left_by_recall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd) |-> rcl);

  a_r6_store_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(nv) |-> $past(rcl && wel));

  a_r9_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(8 + WIDTH));
endmodule

bind snvram snvram_chk #(.WIDTH(WIDTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .dout_en(dout_en),
  .wel(wel), .rcl(rcl), .pd(pd), .nv(nv), .cnt(cnt)
);

// File: tb/snvram_test.sv
module snvram_test;
  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sclk = 1'b0, din = 1'b0;
  logic dout, dout_en;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  snvram uut (.clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .din(din),
              .dout(dout), .dout_en(dout_en));

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic b);
    din = b;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] v, input int n);
    for (int i = 7; i > 7 - n; i--) pulse(v[i]);
  endtask

  task automatic desel();
    cs = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [7:0] opb(input logic [3:0] a, input logic [2:0] op);
    return {1'b1, a, op};
  endfunction

  task automatic cmd(input logic [2:0] op);
    cs = 1'b1;
    send(opb(4'd0, op), 8);
    desel();
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    cs = 1'b1;
    send(opb(a, 3'b011), 8);
    for (int i = 15; i >= 0; i--) pulse(d[i]);
    desel();
  endtask

  task automatic rd(input logic [3:0] a, input int lead, output logic [15:0] d,
                    output logic en_ok, output logic any_en);
    cs = 1'b1;
    d = '0; en_ok = 1'b1; any_en = 1'b0;
    for (int i = 0; i < lead; i++) pulse(1'b0);
    send(opb(a, 3'b110), 7);
    if (dout_en !== 1'b0) en_ok = 1'b0;
    pulse(1'b0);
    for (int i = 15; i >= 0; i--) begin
      d[i] = dout;
      if (dout_en !== 1'b1) en_ok = 1'b0;
      if (dout_en === 1'b1) any_en = 1'b1;
      pulse(1'b0);
    end
    if (dout_en !== 1'b0) en_ok = 1'b0;
    desel();
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [15:0] exp);
    logic [15:0] d; logic ok, any;
    rd(a, 0, d, ok, any);
    check(tag, d, exp);
  endtask

  task automatic t_reset();
    logic [15:0] d; logic ok, any;
    check("R10 dout_en after reset", {15'd0, dout_en}, 16'd0);
    rd(4'd5, 0, d, ok, any);
    check("R10 ram zero after reset", d, 16'h0000);
    check("R4 read enable window", {15'd0, ok}, 16'd1);
  endtask

  task automatic t_write_gate();
    wr(4'd3, 16'hA5A5);
    rd_chk("R3 write without enable ignored", 4'd3, 16'h0000);
  endtask

  task automatic t_enable();
    logic [15:0] d; logic ok, any;
    cmd(3'b100);
    wr(4'd3, 16'h1234);
    rd(4'd3, 0, d, ok, any);
    check("R2 R3 enabled write", d, 16'h1234);
    check("R4 drive timing", {15'd0, ok}, 16'd1);
    cmd(3'b000);
    wr(4'd3, 16'hFFFF);
    rd_chk("R2 write-disable blocks write", 4'd3, 16'h1234);
  endtask

  task automatic t_store_gate();
    cmd(3'b100);
    wr(4'd5, 16'hBEEF);
    cmd(3'b001);
    cmd(3'b101);
    rd_chk("R6 store without recall latch", 4'd5, 16'h0000);
    rd_chk("R5 recall reloads ram", 4'd3, 16'h0000);
    wr(4'd7, 16'h1111);
    rd_chk("R5 recall clears write enable", 4'd7, 16'h0000);
  endtask

  task automatic t_store();
    cmd(3'b100);
    wr(4'd5, 16'hC3C3);
    cmd(3'b001);
    cmd(3'b100);
    wr(4'd5, 16'h0000);
    rd_chk("R3 overwrite before recall", 4'd5, 16'h0000);
    cmd(3'b101);
    rd_chk("R6 store then recall", 4'd5, 16'hC3C3);
  endtask

  task automatic t_pd();
    logic [15:0] d; logic ok, any;
    cmd(3'b100);
    wr(4'd5, 16'h2222);
    cmd(3'b010);
    cmd(3'b001);
    rd(4'd5, 0, d, ok, any);
    check("R7 read silent in power-down", {15'd0, any}, 16'd0);
    cmd(3'b101);
    rd(4'd5, 0, d, ok, any);
    check("R7 store ignored in power-down", d, 16'hC3C3);
    check("R5 recall leaves power-down", {15'd0, ok}, 16'd1);
  endtask

  task automatic t_abort();
    cs = 1'b1;
    pulse(1'b0);
    desel();
    cmd(3'b100);
    cs = 1'b1;
    send(opb(4'd9, 3'b011), 8);
    for (int i = 0; i < 10; i++) pulse(1'b1);
    desel();
    rd_chk("R8 partial write aborted", 4'd9, 16'h0000);
    cs = 1'b1;
    send(opb(4'd5, 3'b110), 8);
    pulse(1'b0); pulse(1'b0);
    check("R8 mid-read driving", {15'd0, dout_en}, 16'd1);
    cs = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 deselect releases output", {15'd0, dout_en}, 16'd0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_coincide();
    logic [15:0] v = 16'h5A5A;
    cs = 1'b1;
    send(opb(4'd9, 3'b011), 8);
    for (int i = 15; i > 0; i--) pulse(v[i]);
    din = v[0];
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    cs = 1'b0;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
    rd_chk("R8 deselect wins over last edge", 4'd9, 16'h0000);
    wr(4'd9, v);
    rd_chk("R3 write after coincident abort", 4'd9, 16'h5A5A);
  endtask

  task automatic t_one_instr();
    cmd(3'b000);
    cs = 1'b1;
    send(opb(4'd0, 3'b100), 8);
    send(opb(4'd0, 3'b000), 8);
    desel();
    wr(4'd10, 16'hBABE);
    rd_chk("R9 second instruction ignored", 4'd10, 16'hBABE);
  endtask

  task automatic t_lead();
    logic [15:0] d; logic ok, any;
    rd(4'd10, 3, d, ok, any);
    check("R1 leading zeros skipped", d, 16'hBABE);
    check("R1 R4 timing with leading zeros", {15'd0, ok}, 16'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write_gate();
    t_enable();
    t_store_gate();
    t_store();
    t_pd();
    t_abort();
    t_coincide();
    t_one_instr();
    t_lead();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule